// File: doc/BRIEF.md
# Protected Dual Voltage-Code Register Controller

This block is the digital control core of a bus-programmed step-down regulator. It holds two 5-bit voltage codes, a low slot and a high slot. A single setup write strobe loads both slots at once, from two data bytes. On and Off command strobes move an internal bus-enable flag. The converter counts as running when that flag and the external enable input are both high. While it runs, the two slots are frozen.

A select input steers one slot onto the active code output. A read-back word returns both slots, and each slot is followed by a status bit that is low only while the converter runs.

A power-good hold-off output stays low while the converter is stopped. It is released only after a fixed number of clock cycles of running. If the select input changes while the converter runs, the output drops low again for the full interval.

Top module: `vid_guard_core`

## Requirements
- R1: Only `setup_wr` changes register contents. On and Off strobes, even with data present on `wr_lo`/`wr_hi`, leave both slots untouched. An accepted setup write puts `wr_lo` into slot 0 and `wr_hi` into slot 1, visible after the next clock edge.
- R2: While the bus-enable flag and `ext_en` are both high, setup writes are ignored.
- R3: While `ext_en` is low, setup writes are accepted whatever the state of the bus-enable flag.
- R4: An `on_cmd` sets the bus-enable flag and clears the pending-Off count. Two `off_cmd` strobes with no `on_cmd` between them clear the flag; a single one does not. If both strobes arrive in the same cycle, the strobe is treated as On.
- R5: `act_code` equals slot 0 while `sel` is 0 and slot 1 while `sel` is 1.
- R6: `rb_word` is laid out as {slot1, st, slot0, st}, with slot 1 in bits [11:7], st in bit 6, slot 0 in bits [5:1] and st in bit 0. `st` is 0 exactly when the converter runs.
- R7: `pg_tmr` is 0 whenever the converter is stopped. After the converter starts, `pg_tmr` goes to 1 once HOLD_CYCLES clock edges have passed while it runs.
- R8: A change of `sel` while the converter runs reloads the full HOLD_CYCLES count. This also applies when the change falls inside an interval that is already counting.
- R9: After reset, both slots are 0, the bus-enable flag and the pending-Off count are clear, and `pg_tmr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_wr | input | 1 | Setup write strobe, loads both slots |
| on_cmd | input | 1 | On command strobe |
| off_cmd | input | 1 | Off command strobe |
| wr_lo | input | 5 | Data for slot 0 |
| wr_hi | input | 5 | Data for slot 1 |
| ext_en | input | 1 | External converter enable |
| sel | input | 1 | Slot select for the active code |
| act_code | output | 5 | Active voltage code |
| rb_word | output | 12 | Read-back word {slot1, st, slot0, st} |
| pg_tmr | output | 1 | Power-good hold-off output, high when released |

## Verification
The hardest state to reach from the ports is a `sel` change that lands in the middle of a hold-off interval that is already counting. Reaching it needs a sustained run, so the stimulus has to avoid stray Off pairs and drops of `ext_en` for many cycles. A directed sequence sets this up on purpose. Random phases mix a low rate of `sel` toggles with a rare double-Off, so lock, unlock and retrigger interleave. A directed Off-On-Off sequence shows that the pending count does not carry across an On.

// File: rtl/vid_guard_pkg.sv
// Package: shared command encoding and helpers for the voltage-code controller.
// Assumes command strobes are already synchronous single-cycle pulses.
package vid_guard_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_ON   = 2'd1,
        CMD_OFF  = 2'd2
    } cmd_e;

    // Resolve two strobes into one command; On has priority over Off.
    function automatic cmd_e cmd_decode(input logic on_s, input logic off_s);
        if (on_s)       return CMD_ON;
        else if (off_s) return CMD_OFF;
        else            return CMD_NONE;
    endfunction

    // Read-back status bit: low only while the converter runs.
    function automatic logic status_of(input logic running);
        return ~running;
    endfunction

endpackage

// File: rtl/vid_cmd_fsm.sv
// Module: vid_cmd_fsm
// Tracks the bus-enable flag from On/Off strobes. Two Off strobes with no
// On between them clear the flag; any On sets it and clears the pending count.
// Assumes: strobes are single-cycle, synchronous to clk.
module vid_cmd_fsm
    import vid_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic on_cmd,
    input  logic off_cmd,
    output logic bus_on
);

    logic bus_on_q;
    logic off_pend_q;
    cmd_e cmd;

    // Decode the strobe pair into one command.
    always_comb begin
        cmd = cmd_decode(on_cmd, off_cmd);
    end

    // Flag and pending-Off counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_on_q   <= 1'b0;
            off_pend_q <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_ON: begin
                    bus_on_q   <= 1'b1;
                    off_pend_q <= 1'b0;
                end
                CMD_OFF: begin
                    if (off_pend_q) begin
                        bus_on_q   <= 1'b0;
                        off_pend_q <= 1'b0;
                    end else begin
                        off_pend_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign bus_on = bus_on_q;

endmodule

// File: rtl/vid_reg_bank.sv
// Module: vid_reg_bank
// Two code slots loaded together from a write strobe, a select multiplexer
// for the active code, and the read-back word with status bits.
// Assumes: wr_en already carries the lock gating from the top.
module vid_reg_bank
    import vid_guard_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int NSLOT  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [NSLOT*CODE_W-1:0]    wr_data,
    input  logic                       sel,
    input  logic                       running,
    output logic [CODE_W-1:0]          act_code,
    output logic [NSLOT*(CODE_W+1)-1:0] rb_word
);

    localparam int FIELD_W = CODE_W + 1;

    logic [CODE_W-1:0] slot_q [NSLOT];
    logic              st;

    // Status bit shared by every read-back field.
    always_comb begin
        st = status_of(running);
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        // Hold one slot; load it from its data field on an accepted write.
        always_ff @(posedge clk) begin
            if (!rst_n)     slot_q[g] <= '0;
            else if (wr_en) slot_q[g] <= wr_data[g*CODE_W +: CODE_W];
        end
        // Place this slot and its status bit in the read-back word.
        assign rb_word[g*FIELD_W +: FIELD_W] = {slot_q[g], st};
    end

    // Select the active slot.
    always_comb begin
        act_code = sel ? slot_q[1] : slot_q[0];
    end

endmodule

// File: rtl/vid_hold_timer.sv
// Module: vid_hold_timer
// Power-good hold-off: output low while stopped, released after HOLD_CYCLES
// running edges, reloaded by any sel change while running.
// Assumes: sel is synchronous to clk.
module vid_hold_timer #(
    parameter int HOLD_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic sel,
    output logic pg
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          sel_q;
    logic          sel_chg;

    // Detect a change of sel against its last sampled value.
    always_comb begin
        sel_chg = sel ^ sel_q;
    end

    // Remember sel for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel;
    end

    // Count down while running; reload when stopped or on a sel change.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= LOAD;
        else if (!running)       cnt_q <= LOAD;
        else if (sel_chg)        cnt_q <= LOAD;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // Release only while running and the count has expired.
    always_comb begin
        pg = running && (cnt_q == '0);
    end

endmodule

// File: rtl/vid_guard_core.sv
// Module: vid_guard_core (top)
// Digital control core: command flag, write lock, two code slots,
// active-code select, read-back and power-good hold-off.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module vid_guard_core #(
    parameter int CODE_W      = 5,
    parameter int HOLD_CYCLES = 5000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  setup_wr,
    input  logic                  on_cmd,
    input  logic                  off_cmd,
    input  logic [CODE_W-1:0]     wr_lo,
    input  logic [CODE_W-1:0]     wr_hi,
    input  logic                  ext_en,
    input  logic                  sel,
    output logic [CODE_W-1:0]     act_code,
    output logic [2*CODE_W+1:0]   rb_word,
    output logic                  pg_tmr
);

    logic bus_on;
    logic running;
    logic wr_gate;

    // Converter runs only with both enables; running locks the slots.
    always_comb begin
        running = bus_on & ext_en;
        wr_gate = setup_wr & ~running;
    end

    vid_cmd_fsm u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .on_cmd  (on_cmd),
        .off_cmd (off_cmd),
        .bus_on  (bus_on)
    );

    vid_reg_bank #(.CODE_W(CODE_W), .NSLOT(2)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_gate),
        .wr_data  ({wr_hi, wr_lo}),
        .sel      (sel),
        .running  (running),
        .act_code (act_code),
        .rb_word  (rb_word)
    );

    vid_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .sel     (sel),
        .pg      (pg_tmr)
    );

endmodule

// File: rtl/vid_guard_chk.sv
// Module: vid_guard_chk
// Property checker bound into vid_guard_core.
module vid_guard_chk #(
    parameter int CODE_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                setup_wr,
    input logic                ext_en,
    input logic                sel,
    input logic                bus_on,
    input logic [CODE_W-1:0]   wr_lo,
    input logic [2*CODE_W+1:0] rb_word,
    input logic                pg_tmr
);

    logic [CODE_W-1:0] s0, s1;
    logic              st_lo;
    assign s0    = rb_word[CODE_W:1];
    assign s1    = rb_word[2*CODE_W+1:CODE_W+2];
    assign st_lo = rb_word[0];

    // R1
    cmd_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !setup_wr |=> ($stable(s0) && $stable(s1)));

    // R2
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_on && ext_en) |=> ($stable(s0) && $stable(s1)));

    // R3
    unlock_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en && setup_wr) |=> (s0 == $past(wr_lo)));

    // R7
    pg_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_tmr |-> !st_lo);

    // R8
    retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_on && ext_en && (sel != $past(sel))) |=> !pg_tmr);

endmodule

bind vid_guard_core vid_guard_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .setup_wr (setup_wr),
    .ext_en   (ext_en),
    .sel      (sel),
    .bus_on   (bus_on),
    .wr_lo    (wr_lo),
    .rb_word  (rb_word),
    .pg_tmr   (pg_tmr)
);

// File: tb/vid_guard_core_test.sv
module vid_guard_core_test;

    localparam int W    = 5;
    localparam int HOLD = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic setup_wr = 0, on_cmd = 0, off_cmd = 0, ext_en = 0, sel = 0;
    logic [W-1:0] wr_lo = '0, wr_hi = '0;
    logic [W-1:0] act_code;
    logic [2*W+1:0] rb_word;
    logic pg_tmr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench reference state.
    logic m_on, m_pend, m_selq;
    logic [W-1:0] m_r0, m_r1;
    int m_cnt;

    always #5 clk = ~clk;

    vid_guard_core #(.CODE_W(W), .HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .setup_wr(setup_wr), .on_cmd(on_cmd),
        .off_cmd(off_cmd), .wr_lo(wr_lo), .wr_hi(wr_hi), .ext_en(ext_en),
        .sel(sel), .act_code(act_code), .rb_word(rb_word), .pg_tmr(pg_tmr)
    );

    function automatic logic exp_running();
        return m_on & ext_en;
    endfunction
    function automatic logic [2*W+1:0] exp_rb();
        logic st = ~exp_running();
        return {m_r1, st, m_r0, st};
    endfunction
    function automatic logic [W-1:0] exp_act();
        return sel ? m_r1 : m_r0;
    endfunction
    function automatic logic exp_pg();
        return exp_running() && (m_cnt == 0);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_on = 0; m_pend = 0; m_selq = 0; m_r0 = '0; m_r1 = '0; m_cnt = HOLD;
    endtask

    // Advance one clock: update reference, then compare on the falling edge.
    task automatic cycle();
        logic run;
        @(posedge clk);
        run = exp_running();
        if (!rst_n) model_reset();
        else begin
            if (setup_wr && !run) begin m_r0 = wr_lo; m_r1 = wr_hi; end
            if (!run || (sel != m_selq)) m_cnt = HOLD;
            else if (m_cnt != 0) m_cnt--;
            m_selq = sel;
            if (on_cmd) begin m_on = 1; m_pend = 0; end
            else if (off_cmd) begin
                if (m_pend) begin m_on = 0; m_pend = 0; end
                else m_pend = 1;
            end
        end
        @(negedge clk);
        check("R5 act_code", 32'(act_code), 32'(exp_act()));
        check("R1/R2/R3/R6 rb_word", 32'(rb_word), 32'(exp_rb()));
        check("R7/R8 pg_tmr", 32'(pg_tmr), 32'(exp_pg()));
    endtask

    task automatic idle();
        setup_wr = 0; on_cmd = 0; off_cmd = 0;
    endtask

    task automatic wr(input logic [W-1:0] lo, input logic [W-1:0] hi);
        wr_lo = lo; wr_hi = hi; setup_wr = 1; cycle(); idle();
    endtask

    initial begin
        void'($urandom(32'h5eed1));
        model_reset();
        rst_n = 0;
        repeat (3) cycle();
        rst_n = 1;
        // R9 reset state
        check("R9 reset rb_word", 32'(rb_word), {20'd0, 12'b0000_01_00000_1});
        check("R9 reset pg_tmr", 32'(pg_tmr), 0);

        // R3: unlocked write, slot order
        ext_en = 0;
        wr(5'h0A, 5'h15); cycle();
        check("R3 slot0 loaded", 32'(rb_word[5:1]), 32'h0A);
        check("R3 slot1 loaded", 32'(rb_word[11:7]), 32'h15);

        // R1: On strobe with data does not write
        wr_lo = 5'h1F; wr_hi = 5'h1F; on_cmd = 1; cycle(); idle(); cycle();
        check("R1 on keeps slot0", 32'(rb_word[5:1]), 32'h0A);

        // Running now: R2 lock
        ext_en = 1; cycle();
        check("R6 status when running", 32'(rb_word[0]), 0);
        wr(5'h03, 5'h04); cycle();
        check("R2 locked slot0", 32'(rb_word[5:1]), 32'h0A);

        // R7 release after HOLD
        repeat (HOLD + 2) cycle();
        check("R7 released", 32'(pg_tmr), 1);

        // R8 retrigger mid-interval
        sel = 1; repeat (HOLD / 2) cycle();
        check("R8 low after toggle", 32'(pg_tmr), 0);
        sel = 0; repeat (HOLD - 1) cycle();
        check("R8 still low after reload", 32'(pg_tmr), 0);
        repeat (3) cycle();
        check("R8 released after reload", 32'(pg_tmr), 1);

        // R4: Off, On, Off keeps flag set
        off_cmd = 1; cycle(); idle(); on_cmd = 1; cycle(); idle();
        off_cmd = 1; cycle(); idle(); cycle();
        check("R4 single off keeps run", 32'(rb_word[0]), 0);
        off_cmd = 1; cycle(); idle(); cycle();
        check("R4 double off stops", 32'(rb_word[0]), 1);
        check("R7 low when stopped", 32'(pg_tmr), 0);
        // R4: simultaneous strobes act as On
        on_cmd = 1; off_cmd = 1; cycle(); idle(); cycle();
        check("R4 on wins", 32'(rb_word[0]), 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            setup_wr = ($urandom % 4) == 0;
            on_cmd   = ($urandom % 12) == 0;
            off_cmd  = ($urandom % 10) == 0;
            wr_lo    = W'($urandom);
            wr_hi    = W'($urandom);
            if (($urandom % 50) == 0) ext_en = ~ext_en;
            if (($urandom % 30) == 0) sel = ~sel;
            cycle();
        end
        idle();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule